// File: doc/BRIEF.md
# Video Controller Command Port Decoder

This block sits behind the control port of a video controller and turns the 16-bit words written there into state that the rest of the controller uses. A word either programs one of the controller's internal 8-bit registers directly, or forms half of a two-word command. The command carries a 16-bit memory pointer and a 6-bit access code whose fields are split across the two words.

The decoder owns the pointer, the access code, a two-bit latch that remembers the top pointer bits, and a flag that marks an incomplete command. It emits a one-cycle strobe for each accepted register write. When a completed command asks for a block transfer and transfers are enabled, it emits a one-cycle request for one of three transfer kinds. Each data-port access advances the pointer by a programmable step. The access code is also decoded into the memory that a data read or a data write reaches.

The decoder keeps private copies of the three registers it needs: mode register 1, the step register 15 and the transfer-source register 23. All of them clear on reset. The memories and the transfer engines lie outside this block.

Top module: `cpd_ctrl_port`

## Requirements
- R1: After synchronous reset the pointer, access code, incomplete-command flag, top-bit latch, register copies and all strobes are zero.
- R2: With no command incomplete, a control word with bits 15:14 = 2'b10 is a register write. In the next cycle `rw_strobe` is high for exactly one cycle, with `rw_index` = word[12:8] and `rw_value` = word[7:0]. The incomplete flag stays low.
- R3: With no command incomplete, any control word loads pointer[13:0] from word[13:0], pointer[15:14] from the latch and code[1:0] from word[15:14]. Code[5:2] is kept. If word[15:14] is not 2'b10, the incomplete flag is set.
- R4: While a command is incomplete, the next control word is its second half, whatever its top bits. It sets pointer[15:14] = word[1:0] and code[5:2] = word[7:4], keeps pointer[13:0] and code[1:0], clears the flag, and copies word[1:0] into the latch.
- R5: A second half with word[7] set (code bit 5), while bit 4 of register 1 is set, raises one transfer request in the next cycle for one cycle. Register 23 bits 7:6 select it: 2'b0x gives `dma_ext_go`, 2'b10 gives `dma_fill_go` and 2'b11 gives `dma_copy_go`. No request is raised when bit 4 is clear.
- R6: A register write to an index above 10 gives no strobe and leaves the register copies unchanged, unless bit 2 of register 1 is set.
- R7: A status read, data read or data write clears the incomplete flag.
- R8: Each data read or data write adds register 15 to the pointer, modulo 65536. A status read leaves the pointer unchanged.
- R9: `rd_target` decodes code[3:0] as 0000→1 (video RAM), 1000→2 (colour RAM), 0100→3 (scroll RAM), else 0. `wr_target` decodes 0001→1, 0011→2, 0101→3, else 0.
- R10: A control word that arrives in the same cycle as a data or status access is dropped. The access still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control-port write strobe |
| ctl_word | input | 16 | Control-port write data |
| dat_re | input | 1 | Data-port read strobe |
| dat_we | input | 1 | Data-port write strobe |
| stat_re | input | 1 | Status-port read strobe |
| cmd_addr | output | 16 | Memory pointer |
| cmd_code | output | 6 | Access code |
| cmd_pending | output | 1 | First half of a command seen, second half awaited |
| rw_strobe | output | 1 | Register write pulse |
| rw_index | output | 5 | Register index of the pulse |
| rw_value | output | 8 | Register value of the pulse |
| dma_ext_go | output | 1 | Request: transfer from the external bus |
| dma_fill_go | output | 1 | Request: arm a fill |
| dma_copy_go | output | 1 | Request: start a memory copy |
| rd_target | output | 2 | Memory reached by a data read |
| wr_target | output | 2 | Memory reached by a data write |

## Verification
The pointer, code, flag, register strobe and transfer requests are all registered. Each is due at the first rising edge after the stimulus cycle, and the strobes last only that one cycle. The targets follow the code register combinationally, so they change at that same edge. The bench drives every access at a falling edge, removes it at the next falling edge, and reads all outputs at that point. Strobe checks are followed by an idle cycle to show that the pulse has fallen.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    localparam int WORD_W     = 16;
    localparam int ADDR_W     = 16;
    localparam int CODE_W     = 6;
    localparam int IDX_W      = 5;
    localparam int VAL_W      = 8;
    localparam int LOW_ADDR_W = 14;
    localparam int HI_ADDR_W  = ADDR_W - LOW_ADDR_W;
    localparam int LOW_CODE_W = 2;
    localparam int HI_CODE_W  = CODE_W - LOW_CODE_W;

    localparam logic [IDX_W-1:0] IDX_MODE2      = 5'd1;
    localparam logic [IDX_W-1:0] IDX_STEP       = 5'd15;
    localparam logic [IDX_W-1:0] IDX_XSRC       = 5'd23;
    localparam logic [IDX_W-1:0] IDX_OPEN_LIMIT = 5'd10;

    localparam int MODE2_OPEN_BIT = 2;
    localparam int MODE2_XFER_BIT = 4;

    localparam int N_SHADOW = 3;
    localparam int SH_MODE2 = 0;
    localparam int SH_STEP  = 1;
    localparam int SH_XSRC  = 2;
    localparam logic [N_SHADOW*IDX_W-1:0] SHADOW_IDX = {IDX_XSRC, IDX_STEP, IDX_MODE2};

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_VRAM  = 2'd1,
        TGT_CRAM  = 2'd2,
        TGT_VSRAM = 2'd3
    } mem_tgt_e;

    typedef enum logic [1:0] {
        XFER_NONE = 2'd0,
        XFER_EXT  = 2'd1,
        XFER_FILL = 2'd2,
        XFER_COPY = 2'd3
    } xfer_e;

    typedef struct packed {
        logic                  is_reg;
        logic [IDX_W-1:0]      idx;
        logic [VAL_W-1:0]      val;
        logic [LOW_ADDR_W-1:0] lo_addr;
        logic [LOW_CODE_W-1:0] lo_code;
        logic [HI_ADDR_W-1:0]  hi_addr;
        logic [HI_CODE_W-1:0]  hi_code;
    } ctl_fields_t;

    function automatic ctl_fields_t split_word(input logic [WORD_W-1:0] w);
        ctl_fields_t f;
        f.is_reg  = (w[15:14] == 2'b10);
        f.idx     = w[12:8];
        f.val     = w[7:0];
        f.lo_addr = w[LOW_ADDR_W-1:0];
        f.lo_code = w[15:14];
        f.hi_addr = w[1:0];
        f.hi_code = w[7:4];
        return f;
    endfunction

    function automatic mem_tgt_e read_target(input logic [CODE_W-1:0] c);
        case (c[3:0])
            4'b0000: return TGT_VRAM;
            4'b1000: return TGT_CRAM;
            4'b0100: return TGT_VSRAM;
            default: return TGT_NONE;
        endcase
    endfunction

    function automatic mem_tgt_e write_target(input logic [CODE_W-1:0] c);
        case (c[3:0])
            4'b0001: return TGT_VRAM;
            4'b0011: return TGT_CRAM;
            4'b0101: return TGT_VSRAM;
            default: return TGT_NONE;
        endcase
    endfunction

    function automatic xfer_e xfer_kind(input logic [1:0] sel);
        case (sel)
            2'b10:   return XFER_FILL;
            2'b11:   return XFER_COPY;
            default: return XFER_EXT;
        endcase
    endfunction

endpackage

// File: rtl/cpd_cmd_regs.sv
module cpd_cmd_regs
    import cpd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_we,
    input  ctl_fields_t         fields,
    input  logic                dat_re,
    input  logic                dat_we,
    input  logic                stat_re,
    input  logic [VAL_W-1:0]    step,
    output logic [ADDR_W-1:0]   addr,
    output logic [CODE_W-1:0]   code,
    output logic                pending,
    output logic                reg_req,
    output logic                second_ok
);

    logic                 any_access;
    logic                 ctl_ok;
    logic [HI_ADDR_W-1:0] top_latch;

    assign any_access = dat_re | dat_we | stat_re;
    assign ctl_ok     = ctl_we & ~any_access;
    assign reg_req    = ctl_ok & ~pending & fields.is_reg;
    assign second_ok  = ctl_ok & pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr      <= '0;
            code      <= '0;
            pending   <= 1'b0;
            top_latch <= '0;
        end else if (any_access) begin
            pending <= 1'b0;
            if (dat_re | dat_we) begin
                addr <= addr + ADDR_W'(step);
            end
        end else if (ctl_we) begin
            if (!pending) begin
                addr <= {top_latch, fields.lo_addr};
                code <= {code[CODE_W-1:LOW_CODE_W], fields.lo_code};
                if (!fields.is_reg) begin
                    pending <= 1'b1;
                end
            end else begin
                addr      <= {fields.hi_addr, addr[LOW_ADDR_W-1:0]};
                code      <= {fields.hi_code, code[LOW_CODE_W-1:0]};
                top_latch <= fields.hi_addr;
                pending   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cpd_shadow_regs.sv
module cpd_shadow_regs
    import cpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VAL_W-1:0]  wr_val,
    output logic              strobe,
    output logic [IDX_W-1:0]  strobe_idx,
    output logic [VAL_W-1:0]  strobe_val,
    output logic [VAL_W-1:0]  mode2,
    output logic [VAL_W-1:0]  step,
    output logic [VAL_W-1:0]  xsrc
);

    logic [VAL_W-1:0] copy_q [N_SHADOW];
    logic             accept;

    assign accept = wr_req & ((wr_idx <= IDX_OPEN_LIMIT) | copy_q[SH_MODE2][MODE2_OPEN_BIT]);

    for (genvar g = 0; g < N_SHADOW; g++) begin : g_copy
        localparam logic [IDX_W-1:0] MY_IDX = SHADOW_IDX[g*IDX_W +: IDX_W];
        always_ff @(posedge clk) begin
            if (rst) begin
                copy_q[g] <= '0;
            end else if (accept && (wr_idx == MY_IDX)) begin
                copy_q[g] <= wr_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe     <= 1'b0;
            strobe_idx <= '0;
            strobe_val <= '0;
        end else begin
            strobe <= accept;
            if (accept) begin
                strobe_idx <= wr_idx;
                strobe_val <= wr_val;
            end
        end
    end

    assign mode2 = copy_q[SH_MODE2];
    assign step  = copy_q[SH_STEP];
    assign xsrc  = copy_q[SH_XSRC];

endmodule

// File: rtl/cpd_xfer_launch.sv
module cpd_xfer_launch
    import cpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       second_ok,
    input  logic       want_xfer,
    input  logic       xfer_enabled,
    input  logic [1:0] mode_sel,
    output logic       go_ext,
    output logic       go_fill,
    output logic       go_copy
);

    xfer_e next_kind;
    xfer_e kind_q;

    always_comb begin
        next_kind = XFER_NONE;
        if (second_ok && want_xfer && xfer_enabled) begin
            next_kind = xfer_kind(mode_sel);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= XFER_NONE;
        end else begin
            kind_q <= next_kind;
        end
    end

    assign go_ext  = (kind_q == XFER_EXT);
    assign go_fill = (kind_q == XFER_FILL);
    assign go_copy = (kind_q == XFER_COPY);

endmodule

// File: rtl/cpd_ctrl_port.sv
module cpd_ctrl_port
    import cpd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_we,
    input  logic [15:0] ctl_word,
    input  logic        dat_re,
    input  logic        dat_we,
    input  logic        stat_re,
    output logic [15:0] cmd_addr,
    output logic [5:0]  cmd_code,
    output logic        cmd_pending,
    output logic        rw_strobe,
    output logic [4:0]  rw_index,
    output logic [7:0]  rw_value,
    output logic        dma_ext_go,
    output logic        dma_fill_go,
    output logic        dma_copy_go,
    output logic [1:0]  rd_target,
    output logic [1:0]  wr_target
);

    ctl_fields_t      fields;
    logic             reg_req;
    logic             second_ok;
    logic [VAL_W-1:0] shadow_mode2;
    logic [VAL_W-1:0] shadow_step;
    logic [VAL_W-1:0] shadow_xsrc;

    assign fields = split_word(ctl_word);

    cpd_cmd_regs u_cmd (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .fields    (fields),
        .dat_re    (dat_re),
        .dat_we    (dat_we),
        .stat_re   (stat_re),
        .step      (shadow_step),
        .addr      (cmd_addr),
        .code      (cmd_code),
        .pending   (cmd_pending),
        .reg_req   (reg_req),
        .second_ok (second_ok)
    );

    cpd_shadow_regs u_shadow (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (reg_req),
        .wr_idx     (fields.idx),
        .wr_val     (fields.val),
        .strobe     (rw_strobe),
        .strobe_idx (rw_index),
        .strobe_val (rw_value),
        .mode2      (shadow_mode2),
        .step       (shadow_step),
        .xsrc       (shadow_xsrc)
    );

    cpd_xfer_launch u_xfer (
        .clk          (clk),
        .rst          (rst),
        .second_ok    (second_ok),
        .want_xfer    (fields.hi_code[HI_CODE_W-1]),
        .xfer_enabled (shadow_mode2[MODE2_XFER_BIT]),
        .mode_sel     (shadow_xsrc[7:6]),
        .go_ext       (dma_ext_go),
        .go_fill      (dma_fill_go),
        .go_copy      (dma_copy_go)
    );

    assign rd_target = read_target(cmd_code);
    assign wr_target = write_target(cmd_code);

endmodule

// File: rtl/cpd_ctrl_port_chk.sv
module cpd_ctrl_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        ctl_we,
    input logic [15:0] ctl_word,
    input logic        dat_re,
    input logic        dat_we,
    input logic        stat_re,
    input logic [15:0] cmd_addr,
    input logic [5:0]  cmd_code,
    input logic        cmd_pending,
    input logic        rw_strobe,
    input logic [4:0]  rw_index,
    input logic [7:0]  rw_value,
    input logic        dma_ext_go,
    input logic        dma_fill_go,
    input logic        dma_copy_go,
    input logic        open_all,
    input logic [7:0]  step
);

    logic acc;
    logic ctl_alone;
    logic any_go;
    assign acc       = dat_re | dat_we | stat_re;
    assign ctl_alone = ctl_we & ~acc;
    assign any_go    = dma_ext_go | dma_fill_go | dma_copy_go;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (cmd_addr == 16'h0000 && cmd_code == 6'h00 && !cmd_pending && !rw_strobe && !any_go)); // R1

    AST_REG_STROBE: assert property (@(posedge clk) disable iff (rst)
        (ctl_alone && !cmd_pending && ctl_word[15:14] == 2'b10 && ctl_word[12:8] <= 5'd10)
        |=> (rw_strobe && rw_index == $past(ctl_word[12:8]) && rw_value == $past(ctl_word[7:0]) && !cmd_pending)); // R2

    AST_FIRST_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (ctl_alone && !cmd_pending)
        |=> (cmd_addr[13:0] == $past(ctl_word[13:0]) && cmd_code[1:0] == $past(ctl_word[15:14]))); // R3

    AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        (ctl_alone && !cmd_pending && ctl_word[15:14] != 2'b10) |=> cmd_pending); // R3

    AST_SECOND_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (ctl_alone && cmd_pending)
        |=> (!cmd_pending && !rw_strobe && cmd_addr[15:14] == $past(ctl_word[1:0])
             && cmd_code[5:2] == $past(ctl_word[7:4]) && $stable(cmd_addr[13:0]))); // R4

    AST_XFER_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dma_ext_go, dma_fill_go, dma_copy_go})); // R5

    AST_XFER_CAUSE: assert property (@(posedge clk) disable iff (rst)
        any_go |-> $past(ctl_alone && cmd_pending && ctl_word[7])); // R5

    AST_GATED_INDEX: assert property (@(posedge clk) disable iff (rst)
        (ctl_alone && !cmd_pending && ctl_word[15:14] == 2'b10 && ctl_word[12:8] > 5'd10 && !open_all)
        |=> !rw_strobe); // R6

    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
        acc |=> !cmd_pending); // R7

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (dat_re || dat_we) |=> (cmd_addr == 16'($past(cmd_addr) + 16'($past(step))))); // R8

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stat_re && !dat_re && !dat_we) |=> $stable(cmd_addr)); // R8

    AST_CTL_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && acc) |=> (!rw_strobe && !any_go && $stable(cmd_code))); // R10

endmodule

bind cpd_ctrl_port cpd_ctrl_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_we      (ctl_we),
    .ctl_word    (ctl_word),
    .dat_re      (dat_re),
    .dat_we      (dat_we),
    .stat_re     (stat_re),
    .cmd_addr    (cmd_addr),
    .cmd_code    (cmd_code),
    .cmd_pending (cmd_pending),
    .rw_strobe   (rw_strobe),
    .rw_index    (rw_index),
    .rw_value    (rw_value),
    .dma_ext_go  (dma_ext_go),
    .dma_fill_go (dma_fill_go),
    .dma_copy_go (dma_copy_go),
    .open_all    (shadow_mode2[2]),
    .step        (shadow_step)
);

// File: tb/tb_cpd_ctrl_port.sv
module tb_cpd_ctrl_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_word = 16'h0000;
    logic        dat_re = 1'b0;
    logic        dat_we = 1'b0;
    logic        stat_re = 1'b0;
    logic [15:0] cmd_addr;
    logic [5:0]  cmd_code;
    logic        cmd_pending;
    logic        rw_strobe;
    logic [4:0]  rw_index;
    logic [7:0]  rw_value;
    logic        dma_ext_go;
    logic        dma_fill_go;
    logic        dma_copy_go;
    logic [1:0]  rd_target;
    logic [1:0]  wr_target;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cpd_ctrl_port dut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_word(ctl_word),
        .dat_re(dat_re), .dat_we(dat_we), .stat_re(stat_re),
        .cmd_addr(cmd_addr), .cmd_code(cmd_code), .cmd_pending(cmd_pending),
        .rw_strobe(rw_strobe), .rw_index(rw_index), .rw_value(rw_value),
        .dma_ext_go(dma_ext_go), .dma_fill_go(dma_fill_go), .dma_copy_go(dma_copy_go),
        .rd_target(rd_target), .wr_target(wr_target)
    );

    localparam logic [1:0] OP_CTL = 2'd0;
    localparam logic [1:0] OP_DRD = 2'd1;
    localparam logic [1:0] OP_DWR = 2'd2;
    localparam logic [1:0] OP_SRD = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] word;
        logic [15:0] exp_addr;
        logic [5:0]  exp_code;
        logic        exp_pend;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{OP_CTL, 16'h4000, 16'h0000, 6'h01, 1'b1},
        '{OP_CTL, 16'h0002, 16'h8000, 6'h01, 1'b0},
        '{OP_DWR, 16'h0000, 16'h8002, 6'h01, 1'b0},
        '{OP_DRD, 16'h0000, 16'h8004, 6'h01, 1'b0},
        '{OP_CTL, 16'h8A00, 16'h8A00, 6'h02, 1'b0},
        '{OP_CTL, 16'hC010, 16'h8010, 6'h03, 1'b1},
        '{OP_SRD, 16'h0000, 16'h8010, 6'h03, 1'b0},
        '{OP_CTL, 16'h0005, 16'h8005, 6'h00, 1'b1},
        '{OP_CTL, 16'h0010, 16'h0005, 6'h04, 1'b0},
        '{OP_DRD, 16'h0000, 16'h0007, 6'h04, 1'b0},
        '{OP_CTL, 16'h8F04, 16'h0F04, 6'h06, 1'b0},
        '{OP_DWR, 16'h0000, 16'h0F08, 6'h06, 1'b0},
        '{OP_CTL, 16'hFFFF, 16'h3FFF, 6'h07, 1'b1},
        '{OP_CTL, 16'h8003, 16'hFFFF, 6'h03, 1'b0},
        '{OP_DWR, 16'h0000, 16'h0003, 6'h03, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cycle(input logic c, input logic r, input logic w,
                         input logic s, input logic [15:0] d);
        @(negedge clk);
        ctl_we = c; ctl_word = d; dat_re = r; dat_we = w; stat_re = s;
        @(negedge clk);
        ctl_we = 1'b0; dat_re = 1'b0; dat_we = 1'b0; stat_re = 1'b0;
    endtask

    task automatic ctl(input logic [15:0] d);
        cycle(1'b1, 1'b0, 1'b0, 1'b0, d);
    endtask

    task automatic idle();
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
    endtask

    task automatic chk_go(input string req, input logic [2:0] exp);
        chk(req, "xfer {ext,fill,copy}", {13'd0, dma_ext_go, dma_fill_go, dma_copy_go}, {13'd0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1", "addr", cmd_addr, 16'h0000);
        chk("R1", "code", {10'd0, cmd_code}, 16'h0000);
        chk("R1", "pending", {15'd0, cmd_pending}, 16'h0000);
        chk("R1", "strobe", {15'd0, rw_strobe}, 16'h0000);
        chk_go("R1", 3'b000);

        // R6 gated index while mode bit 2 clear; latch from reset is zero (R1)
        ctl(16'h8F05);
        chk("R6", "strobe gated", {15'd0, rw_strobe}, 16'h0000);
        chk("R1", "addr with reset latch", cmd_addr, 16'h0F05);
        cycle(1'b0, 1'b1, 1'b0, 1'b0, 16'h0000);
        chk("R6", "step unchanged after gated write", cmd_addr, 16'h0F05);

        // R2 register write strobe
        ctl(16'h8114);
        chk("R2", "strobe", {15'd0, rw_strobe}, 16'h0001);
        chk("R2", "index", {11'd0, rw_index}, 16'h0001);
        chk("R2", "value", {8'd0, rw_value}, 16'h0014);
        chk("R2", "pending", {15'd0, cmd_pending}, 16'h0000);
        idle();
        chk("R2", "strobe falls", {15'd0, rw_strobe}, 16'h0000);

        ctl(16'h8F02);
        chk("R6", "strobe open", {15'd0, rw_strobe}, 16'h0001);
        chk("R6", "index open", {11'd0, rw_index}, 16'h000F);

        // R3 R4 R7 R8 table walk
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = VECS[i];
            cycle(v.op == OP_CTL, v.op == OP_DRD, v.op == OP_DWR, v.op == OP_SRD, v.word);
            chk("R3/R4/R7/R8", $sformatf("vec%0d addr", i), cmd_addr, v.exp_addr);
            chk("R3/R4", $sformatf("vec%0d code", i), {10'd0, cmd_code}, {10'd0, v.exp_code});
            chk("R3/R4/R7", $sformatf("vec%0d pending", i), {15'd0, cmd_pending}, {15'd0, v.exp_pend});
        end

        // R5 transfer requests
        ctl(16'h9780);
        ctl(16'h0000);
        chk_go("R5", 3'b000);
        ctl(16'h0080);
        chk_go("R5", 3'b010);
        idle();
        chk_go("R5", 3'b000);
        ctl(16'h97C0);
        ctl(16'h0000);
        ctl(16'h0080);
        chk_go("R5", 3'b001);
        ctl(16'h9740);
        ctl(16'h0000);
        ctl(16'h0080);
        chk_go("R5", 3'b100);
        ctl(16'h8104);
        ctl(16'h0000);
        ctl(16'h0080);
        chk_go("R5", 3'b000);

        // R9 target decode
        ctl(16'h0000); ctl(16'h0020);
        chk("R9", "rd cram", {14'd0, rd_target}, 16'h0002);
        chk("R9", "wr none", {14'd0, wr_target}, 16'h0000);
        ctl(16'hC000); ctl(16'h0000);
        chk("R9", "wr cram", {14'd0, wr_target}, 16'h0002);
        chk("R9", "rd none", {14'd0, rd_target}, 16'h0000);
        ctl(16'h4000); ctl(16'h0010);
        chk("R9", "wr vsram", {14'd0, wr_target}, 16'h0003);
        ctl(16'h0000); ctl(16'h0000);
        chk("R9", "rd vram", {14'd0, rd_target}, 16'h0001);
        ctl(16'h4000); ctl(16'h0000);
        chk("R9", "wr vram", {14'd0, wr_target}, 16'h0001);

        // R10 control word dropped under a data access
        ctl(16'h4000);
        chk("R10", "pending before", {15'd0, cmd_pending}, 16'h0001);
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 16'h8F11);
        chk("R10", "pending cleared", {15'd0, cmd_pending}, 16'h0000);
        chk("R10", "addr stepped", cmd_addr, 16'h0004);
        chk("R10", "no strobe", {15'd0, rw_strobe}, 16'h0000);
        cycle(1'b0, 1'b1, 1'b0, 1'b0, 16'h0000);
        chk("R10", "step kept", cmd_addr, 16'h0008);

        // R7 data write clears pending, next word is a register write
        ctl(16'h4000);
        cycle(1'b0, 1'b0, 1'b1, 1'b0, 16'h0000);
        chk("R7", "pending cleared by write", {15'd0, cmd_pending}, 16'h0000);
        ctl(16'h8F06);
        chk("R7", "next word is register write", {15'd0, rw_strobe}, 16'h0001);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule